// File: doc/BRIEF.md
# Multichannel ADC Acquisition Controller

This block sequences conversions for a sixteen-input sampling front end and collects the results. Software programs it through a byte-wide register port. It picks what starts a conversion: a register strobe, a tick from an external pacer timer, or an external trigger pin. It then issues start pulses to a converter, modelled as a start/done handshake. Each returned 16-bit word is stored in a first-word-fall-through sample FIFO that software drains through a separate pop port.

With channel scanning enabled, consecutive conversions walk from channel 0 up to the programmed channel number and wrap. With scanning disabled, every conversion uses the programmed channel. Two interrupt request lines are raised. The data request fires on each completed conversion or when the FIFO reaches half full. The auxiliary request fires on a pacer tick or on an external trigger. The status flags read active low. The FIFO is emptied by setting its disable bit and clearing it again.

Top module: `adc_acq_ctrl`

## Requirements
- R1: After reset every register is 0. The status byte (address 1) reads 0x60, the readback byte (address 4) reads 0x00, and neither conv_start nor either interrupt line is high.
- R2: Address 4 reads {overflow, interrupt control[2:0], mode[3:0]}. Mode bit 0 is scan enable, bit 1 selects pacer over strobe, bit 2 selects the external trigger over both, and bit 3 is a stored pretrigger flag. Address 0 reads the channel in bits 3:0. Writes land at the clock edge, at address 0 for the channel, 1 for the range (bits 2:0), 2 for the mode and 3 for interrupt control.
- R3: The accepted trigger is ext_trig when mode bit 2 is set. Otherwise it is pacer_tick when mode bit 1 is set. Otherwise it is a write to address 5. The two unselected sources start nothing.
- R4: An accepted trigger raises conv_start for exactly one cycle, in the cycle after the trigger, and sets busy until conv_done is seen. Triggers that arrive while busy are ignored.
- R5: With scanning off, conv_chan is the channel register. With scanning on, successive conversions use 0, 1, … up to the channel register and then return to 0. A write to address 0 or address 2 restarts the scan at 0.
- R6: Every conv_data word returned with conv_done is stored in order and presented on smp_data. smp_pop removes the oldest word. The FIFO holds 1024 words.
- R7: The status byte is {busy, not full, below half (count < 512), not empty, 0, range[2:0]}.
- R8: A result that arrives while the FIFO is full is discarded, and the overflow bit (address 4 bit 7) stays set until the FIFO is disabled.
- R9: While interrupt control bit 2 is set, the FIFO is held empty with overflow clear and drops new results. Clearing the bit again resumes storage.
- R10: With interrupt control bit 0 at 0, irq_data is set by each completed conversion. At 1, it is set in the cycle after the FIFO count reaches 512.
- R11: With interrupt control bit 1 at 0, irq_aux is set by pacer_tick. At 1, it is set by ext_trig.
- R12: A write to address 6 clears both interrupt lines. A new event in the same cycle still sets its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| pacer_tick | input | 1 | Pacer timer tick |
| ext_trig | input | 1 | External trigger pulse |
| conv_start | output | 1 | One-cycle converter start |
| conv_chan | output | 4 | Channel for the current conversion |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 16 | Converter result word |
| smp_pop | input | 1 | Remove the oldest stored sample |
| smp_data | output | 16 | Oldest stored sample |
| irq_data | output | 1 | Data interrupt request |
| irq_aux | output | 1 | Auxiliary interrupt request |

## Verification
Conversions are driven by register strobes, pacer ticks and external pulses in turn, each with the other two sources toggled. This shows whether the source selection really gates them. A slow converter receives back-to-back triggers, which tells dropped triggers apart from queued ones. A scanned run of nine conversions over four channels shows the wrap point, and the fixed-channel run that follows shows the scan stopping. A continuous pacer run fills the FIFO past half and past full, which separates the half-full interrupt, the full flag, the sticky overflow and the clearing action of the disable bit.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;

  localparam logic [2:0] ADR_CHAN  = 3'd0;
  localparam logic [2:0] ADR_STAT  = 3'd1;
  localparam logic [2:0] ADR_MODE  = 3'd2;
  localparam logic [2:0] ADR_ICTL  = 3'd3;
  localparam logic [2:0] ADR_RDBK  = 3'd4;
  localparam logic [2:0] ADR_STRB  = 3'd5;
  localparam logic [2:0] ADR_ICLR  = 3'd6;

  // mode bits 3..0
  typedef struct packed {
    logic pretrig;
    logic ext_sel;
    logic pacer_sel;
    logic scan_en;
  } mode_t;

  // interrupt control bits 2..0
  typedef struct packed {
    logic fifo_off;
    logic aux_on_ext;
    logic data_on_half;
  } ictl_t;

  function automatic logic [7:0] status_byte(input logic busy, input logic full,
                                             input logic half, input logic empty,
                                             input logic [3:0] rng);
    return {busy, ~full, ~half, ~empty, rng};
  endfunction

endpackage

// File: rtl/adc_acq_regs.sv
module adc_acq_regs
  import adc_acq_pkg::*;
#(
  parameter int CHAN_W  = 4,
  parameter int RANGE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [2:0]         addr,
  input  logic [7:0]         wdata,
  input  logic               busy,
  input  logic               fifo_full,
  input  logic               fifo_half,
  input  logic               fifo_empty,
  input  logic               fifo_ovf,
  output logic [CHAN_W-1:0]  chan_q,
  output mode_t              mode_q,
  output ictl_t              ictl_q,
  output logic               strobe,
  output logic               irq_clr,
  output logic               scan_restart,
  output logic [7:0]         rdata
);

  logic [RANGE_W-1:0] range_q;
  logic wr_chan, wr_rng, wr_mode, wr_ictl;

  assign wr_chan      = wr && (addr == ADR_CHAN);
  assign wr_rng       = wr && (addr == ADR_STAT);
  assign wr_mode      = wr && (addr == ADR_MODE);
  assign wr_ictl      = wr && (addr == ADR_ICTL);
  assign strobe       = wr && (addr == ADR_STRB);
  assign irq_clr      = wr && (addr == ADR_ICLR);
  assign scan_restart = wr_chan || wr_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= '0;
      range_q <= '0;
      mode_q  <= '0;
      ictl_q  <= '0;
    end else begin
      if (wr_chan) chan_q  <= wdata[CHAN_W-1:0];
      if (wr_rng)  range_q <= wdata[RANGE_W-1:0];
      if (wr_mode) mode_q  <= mode_t'(wdata[3:0]);
      if (wr_ictl) ictl_q  <= ictl_t'(wdata[2:0]);
    end
  end

  always_comb begin
    unique case (addr)
      ADR_CHAN: rdata = 8'(chan_q);
      ADR_STAT: rdata = status_byte(busy, fifo_full, fifo_half, fifo_empty, 4'(range_q));
      ADR_RDBK: rdata = {fifo_ovf, ictl_q, mode_q};
      default:  rdata = 8'h00;
    endcase
  end

  assert_range_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rng |=> $stable(range_q));

endmodule

// File: rtl/adc_acq_seq.sv
module adc_acq_seq #(
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              pacer_sel,
  input  logic              ext_sel,
  input  logic [CHAN_W-1:0] last_chan,
  input  logic              scan_restart,
  input  logic              strobe,
  input  logic              pacer_tick,
  input  logic              ext_trig,
  input  logic              conv_done,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              busy,
  output logic              done_evt
);

  logic              trig_sel;
  logic              fire;
  logic [CHAN_W-1:0] scan_q;
  logic [CHAN_W-1:0] chan_pick;

  function automatic logic [CHAN_W-1:0] scan_step(input logic [CHAN_W-1:0] pos,
                                                  input logic [CHAN_W-1:0] last);
    return (pos >= last) ? '0 : pos + 1'b1;
  endfunction

  assign trig_sel  = ext_sel ? ext_trig : (pacer_sel ? pacer_tick : strobe);
  assign fire      = trig_sel && !busy;
  assign done_evt  = busy && conv_done;
  assign chan_pick = scan_en ? scan_q : last_chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      conv_chan  <= '0;
      busy       <= 1'b0;
      scan_q     <= '0;
    end else begin
      conv_start <= fire;
      if (fire) conv_chan <= chan_pick;
      if (fire)          busy <= 1'b1;
      else if (done_evt) busy <= 1'b0;
      if (scan_restart)           scan_q <= '0;
      else if (fire && scan_en)   scan_q <= scan_step(scan_q, last_chan);
    end
  end

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> busy);

endmodule

// File: rtl/adc_acq_fifo.sv
module adc_acq_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              off,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              half,
  output logic              full,
  output logic              ovf
);

  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;
  localparam int HALF  = DEPTH / 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign half    = (count >= CNT_W'(HALF));
  assign push_ok = push && !full && !off;
  assign pop_ok  = pop && !empty && !off;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else if (off) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
      if (push && full) ovf <= 1'b1;
    end
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !off) |=> ovf);
  assert_off_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (empty && !ovf));

endmodule

// File: rtl/adc_acq_irq.sv
module adc_acq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic data_on_half,
  input  logic aux_on_ext,
  input  logic half,
  input  logic done_evt,
  input  logic pacer_tick,
  input  logic ext_trig,
  input  logic clr,
  output logic irq_data,
  output logic irq_aux
);

  logic half_prev;
  logic half_rise;
  logic ev_data;
  logic ev_aux;

  assign half_rise = half && !half_prev;
  assign ev_data   = data_on_half ? half_rise : done_evt;
  assign ev_aux    = aux_on_ext ? ext_trig : pacer_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_prev <= 1'b0;
      irq_data  <= 1'b0;
      irq_aux   <= 1'b0;
    end else begin
      half_prev <= half;
      irq_data  <= ev_data || (irq_data && !clr);
      irq_aux   <= ev_aux || (irq_aux && !clr);
    end
  end

  assert_clear_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev_data) |=> !irq_data);
  assert_clear_aux_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev_aux) |=> !irq_aux);

endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl
  import adc_acq_pkg::*;
#(
  parameter int CHAN_W  = 4,
  parameter int RANGE_W = 3,
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              pacer_tick,
  input  logic              ext_trig,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              smp_pop,
  output logic [DATA_W-1:0] smp_data,
  output logic              irq_data,
  output logic              irq_aux
);

  logic [CHAN_W-1:0] chan_q;
  mode_t             mode_q;
  ictl_t             ictl_q;
  logic strobe, irq_clr, scan_restart;
  logic busy, done_evt;
  logic f_empty, f_half, f_full, f_ovf;

  adc_acq_regs #(.CHAN_W(CHAN_W), .RANGE_W(RANGE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .fifo_full(f_full), .fifo_half(f_half), .fifo_empty(f_empty),
    .fifo_ovf(f_ovf), .chan_q(chan_q), .mode_q(mode_q), .ictl_q(ictl_q),
    .strobe(strobe), .irq_clr(irq_clr), .scan_restart(scan_restart),
    .rdata(reg_rdata)
  );

  adc_acq_seq #(.CHAN_W(CHAN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .scan_en(mode_q.scan_en),
    .pacer_sel(mode_q.pacer_sel), .ext_sel(mode_q.ext_sel),
    .last_chan(chan_q), .scan_restart(scan_restart), .strobe(strobe),
    .pacer_tick(pacer_tick), .ext_trig(ext_trig), .conv_done(conv_done),
    .conv_start(conv_start), .conv_chan(conv_chan), .busy(busy),
    .done_evt(done_evt)
  );

  adc_acq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .off(ictl_q.fifo_off), .push(done_evt),
    .push_data(conv_data), .pop(smp_pop), .rd_data(smp_data),
    .empty(f_empty), .half(f_half), .full(f_full), .ovf(f_ovf)
  );

  adc_acq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .data_on_half(ictl_q.data_on_half),
    .aux_on_ext(ictl_q.aux_on_ext), .half(f_half), .done_evt(done_evt),
    .pacer_tick(pacer_tick), .ext_trig(ext_trig), .clr(irq_clr),
    .irq_data(irq_data), .irq_aux(irq_aux)
  );

  assert_trig_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.ext_sel && !ext_trig) |=> !conv_start);

endmodule

// File: tb/sim_adc_acq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_acq_ctrl;

  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd1;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        pacer_tick = 1'b0;
  logic        ext_trig = 1'b0;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        conv_done;
  logic [15:0] conv_data;
  logic        smp_pop = 1'b0;
  logic [15:0] smp_data;
  logic        irq_data, irq_aux;

  adc_acq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pacer_tick(pacer_tick),
    .ext_trig(ext_trig), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data), .smp_pop(smp_pop),
    .smp_data(smp_data), .irq_data(irq_data), .irq_aux(irq_aux)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int lat    = 2;
  int n_starts = 0;
  logic [2:0] view = 3'd1;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // converter model
  initial begin
    int cnt;
    logic [3:0]  ch;
    logic [11:0] seq;
    cnt = 0; ch = 0; seq = 0;
    conv_done = 1'b0;
    conv_data = 16'h0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (!rst_n) cnt = 0;
      else if (conv_start) begin
        cnt = lat; ch = conv_chan; n_starts++;
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          conv_done = 1'b1;
          conv_data = {ch, seq};
          seq++;
        end
      end
    end
  end

  // reference model
  logic [15:0] mq[$];
  logic       m_busy, m_start, m_ovf, m_hfp, m_irqd, m_irqa;
  logic [3:0] m_cchan, m_pos, m_chan, m_mode;
  logic [2:0] m_rng, m_ictl;

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {4'b0, m_chan};
      3'd1: return {m_busy, mq.size() != DEPTH, mq.size() < DEPTH/2, mq.size() != 0, 1'b0, m_rng};
      3'd4: return {m_ovf, m_ictl, m_mode};
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    logic w_sw, w_clr, trig, fire, done, hf, ev_d, ev_a;
    int sz;
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        m_busy = 0; m_start = 0; m_ovf = 0; m_hfp = 0; m_irqd = 0; m_irqa = 0;
        m_cchan = 0; m_pos = 0; m_chan = 0; m_mode = 0; m_rng = 0; m_ictl = 0;
        mq.delete();
      end else begin
        w_sw  = reg_wr && reg_addr == 3'd5;
        w_clr = reg_wr && reg_addr == 3'd6;
        trig  = m_mode[2] ? ext_trig : (m_mode[1] ? pacer_tick : w_sw);
        fire  = trig && !m_busy;
        done  = m_busy && conv_done;
        sz    = mq.size();
        hf    = sz >= DEPTH/2;
        ev_d  = m_ictl[0] ? (hf && !m_hfp) : done;
        ev_a  = m_ictl[1] ? ext_trig : pacer_tick;
        m_irqd = ev_d || (m_irqd && !w_clr);
        m_irqa = ev_a || (m_irqa && !w_clr);
        m_hfp  = hf;
        if (m_ictl[2]) begin
          mq.delete(); m_ovf = 0;
        end else begin
          if (smp_pop && sz > 0) void'(mq.pop_front());
          if (done) begin
            if (sz >= DEPTH) m_ovf = 1;
            else mq.push_back(conv_data);
          end
        end
        m_start = fire;
        if (fire) m_cchan = m_mode[0] ? m_pos : m_chan;
        if (fire) m_busy = 1; else if (done) m_busy = 0;
        if (reg_wr && (reg_addr == 3'd0 || reg_addr == 3'd2)) m_pos = 0;
        else if (fire && m_mode[0]) m_pos = (m_pos >= m_chan) ? 4'd0 : m_pos + 4'd1;
        if (reg_wr) begin
          case (reg_addr)
            3'd0: m_chan = reg_wdata[3:0];
            3'd1: m_rng  = reg_wdata[2:0];
            3'd2: m_mode = reg_wdata[3:0];
            3'd3: m_ictl = reg_wdata[2:0];
            default: ;
          endcase
        end
      end
      #2;
      if (rst_n) begin
        chk("R4 conv_start", 32'(conv_start), 32'(m_start));
        if (m_start) chk("R5 conv_chan", 32'(conv_chan), 32'(m_cchan));
        chk("R10 irq_data", 32'(irq_data), 32'(m_irqd));
        chk("R11 irq_aux", 32'(irq_aux), 32'(m_irqa));
        chk(reg_addr == 3'd1 ? "R7 status" : "R2 readback", 32'(reg_rdata), 32'(exp_rd(reg_addr)));
        if (mq.size() > 0) chk("R6 smp_data", 32'(smp_data), 32'(mq[0]));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = view;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] e);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, 32'(reg_rdata), 32'(e));
    reg_addr = view;
  endtask

  task automatic pop_chk(input string tag, input logic [3:0] ech);
    @(negedge clk);
    #1 chk(tag, 32'(smp_data[15:12]), 32'(ech));
    smp_pop = 1'b1;
    @(negedge clk);
    smp_pop = 1'b0;
  endtask

  task automatic drain();
    while (mq.size() > 0) begin
      @(negedge clk); smp_pop = 1'b1;
      @(negedge clk); smp_pop = 1'b0;
    end
  endtask

  task automatic pulse(input bit use_ext);
    @(negedge clk);
    if (use_ext) ext_trig = 1'b1; else pacer_tick = 1'b1;
    @(negedge clk);
    ext_trig = 1'b0; pacer_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired got running exp finished");
    finish_run();
  end

  initial begin
    int n0;
    logic [3:0] exp_seq [9];
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd_chk("R1 status after reset", 3'd1, 8'h60);
    rd_chk("R1 readback after reset", 3'd4, 8'h00);
    chk("R1 irq lines", 32'({irq_data, irq_aux, conv_start}), 32'd0);

    // R2 register readback, pretrigger flag
    wr(3'd2, 8'h08);
    rd_chk("R2 pretrigger readback", 3'd4, 8'h08);
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h05);
    rd_chk("R7 range in status", 3'd1, 8'h65);

    // R3/R6 strobe on fixed channel
    wr(3'd0, 8'h05);
    rd_chk("R2 channel readback", 3'd0, 8'h05);
    repeat (3) begin wr(3'd5, 8'h00); idle(6); end
    pop_chk("R6 first sample chan", 4'd5);
    pop_chk("R6 second sample chan", 4'd5);
    pop_chk("R3 third sample chan", 4'd5);

    // R4 trigger while busy is ignored
    lat = 8;
    n0 = n_starts;
    wr(3'd5, 8'h00); wr(3'd5, 8'h00); wr(3'd5, 8'h00);
    idle(12);
    chk("R4 one start for busy triggers", 32'(n_starts - n0), 32'd1);
    lat = 2;
    drain();

    // R5 scanning over 0..3
    wr(3'd0, 8'h03);
    wr(3'd2, 8'h01);
    repeat (9) begin wr(3'd5, 8'h00); idle(6); end
    exp_seq = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd0, 4'd1, 4'd2, 4'd3, 4'd0};
    for (int i = 0; i < 9; i++) pop_chk("R5 scan order", exp_seq[i]);
    wr(3'd2, 8'h00);
    wr(3'd5, 8'h00); idle(6);
    pop_chk("R5 fixed channel after scan off", 4'd3);

    // R3 pacer source
    wr(3'd2, 8'h02);
    n0 = n_starts;
    wr(3'd5, 8'h00); idle(4);
    chk("R3 strobe ignored in pacer mode", 32'(n_starts - n0), 32'd0);
    pulse(1'b1); idle(4);
    chk("R3 ext ignored in pacer mode", 32'(n_starts - n0), 32'd0);
    pulse(1'b0); idle(6);
    chk("R3 pacer starts", 32'(n_starts - n0), 32'd1);

    // R3 external source
    wr(3'd2, 8'h04);
    n0 = n_starts;
    pulse(1'b0); idle(4);
    chk("R3 pacer ignored in ext mode", 32'(n_starts - n0), 32'd0);
    pulse(1'b1); idle(6);
    chk("R3 ext starts", 32'(n_starts - n0), 32'd1);
    drain();

    // R10/R11/R12 interrupts
    wr(3'd2, 8'h00);
    wr(3'd6, 8'h00);
    chk("R12 clear both", 32'({irq_data, irq_aux}), 32'd0);
    wr(3'd5, 8'h00); idle(6);
    chk("R10 end of conversion irq", 32'(irq_data), 32'd1);
    wr(3'd6, 8'h00);
    pulse(1'b0); idle(1);
    chk("R11 pacer aux irq", 32'(irq_aux), 32'd1);
    wr(3'd6, 8'h00);
    wr(3'd3, 8'h02);
    pulse(1'b0); idle(1);
    chk("R11 pacer ignored for aux", 32'(irq_aux), 32'd0);
    pulse(1'b1); idle(1);
    chk("R11 ext aux irq", 32'(irq_aux), 32'd1);
    wr(3'd6, 8'h00);
    drain();

    // R8/R9/R10 fill, half-full, overflow, disable
    lat = 1;
    wr(3'd3, 8'h04);
    wr(3'd3, 8'h01);
    wr(3'd6, 8'h00);
    wr(3'd2, 8'h02);
    @(negedge clk); pacer_tick = 1'b1;
    while (mq.size() < DEPTH/2 + 2) @(negedge clk);
    chk("R10 half-full irq", 32'(irq_data), 32'd1);
    while (mq.size() < DEPTH) @(negedge clk);
    idle(10);
    pacer_tick = 1'b0;
    idle(4);
    rd_chk("R8 overflow sticky", 3'd4, 8'h92);
    rd_chk("R7 full flags", 3'd1, 8'h15);
    wr(3'd3, 8'h05);
    pulse(1'b0); idle(4);
    rd_chk("R9 disabled holds empty", 3'd1, 8'h65);
    rd_chk("R9 overflow cleared", 3'd4, 8'h52);
    wr(3'd3, 8'h01);
    pulse(1'b0); idle(4);
    rd_chk("R9 storage resumes", 3'd1, 8'h75);
    drain();
    idle(4);
    finish_run();
  end

endmodule